// File: doc/BRIEF.md
# Programmable SPI Frame Master

This block is the serial side of an SPI master. It takes one parallel word at a time over a valid/ready transmit port. It shifts that word out most significant bit first while it drives the bit clock and an active-low frame select. At the same time it shifts a word in from the data input. When the frame is done, the received word is presented for one cycle with a valid strobe.

Each frame latches its settings at the moment the word is accepted. These settings are the frame length (4 to 16 bits), the clock idle level, the sampling phase, the internal loopback and the two-stage bit-rate divider. Changes made while a frame is running therefore apply only to the next word. The transmit port is the only place where back-pressure exists. `tx_ready` is high only while the engine is enabled and idle, and a word moves on a cycle where `tx_valid` and `tx_ready` are both high. A source may hold `tx_valid` with the next word to run frames back to back. The receive side has no ready signal. `rx_valid` is a single-cycle pulse, and the consumer must take `rx_data` in that cycle.

Top module: `spi_frame_master`

## Requirements
- R1: The `size_m1` code (3 to 15) gives a frame of `size_m1`+1 bits. Each frame drives exactly 2×(`size_m1`+1) transitions on `sclk`.
- R2: One half bit lasts H = (P/2)×(`rate`+1) clock cycles. P is `presc` with bit 0 forced to zero, and a P of 0 acts as 2. Bit 0 of `presc` has no effect on timing.
- R3: Outside frames, and in the half bit after the last edge, `sclk` rests at the level of `cpol`.
- R4: With `cpha`=0, input and output bits are captured on the odd-numbered (leading) `sclk` transitions. With `cpha`=1, they are captured on the even-numbered (trailing) transitions.
- R5: The transmitted bits are the low `size_m1`+1 bits of `tx_data`, most significant first. `rx_data` holds the received bits right-justified, and the bits above the frame length are zero.
- R6: With `loop_en`=1, the received word equals the transmitted word and `miso` is ignored.
- R7: `cs_n` falls H cycles before the first `sclk` transition and rises H cycles after the last one. Between two frames, `cs_n` stays high for at least H cycles.
- R8: `busy` is high whenever `cs_n` is low, the engine is finishing a frame, or `tx_valid` is high. Otherwise it is low.
- R9: While `en` is low, `tx_ready` is low and no frame starts.
- R10: Changes to `size_m1`, `cpol`, `cpha`, `loop_en`, `presc` and `rate` during a frame do not affect that frame.
- R11: `rx_valid` is a one-cycle pulse. It rises on the same clock edge as `cs_n` at the end of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new frames to start |
| size_m1 | input | 4 | Frame length minus one (3 to 15) |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | 0: capture on leading edges, 1: capture on trailing edges |
| loop_en | input | 1 | Receive from own output instead of `miso` |
| presc | input | 8 | Even prescale factor (bit 0 ignored) |
| rate | input | 8 | Rate counter value; bit rate divides by `rate`+1 |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine will accept the offered word |
| tx_data | input | 16 | Transmit word, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | 16 | Received word, right-justified, zero above the frame |
| busy | output | 1 | Frame in flight or word waiting |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low frame select |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is a configuration change that lands inside a running frame. It must be shown to leave that frame's length, phase and clock level untouched. The bench waits until `cs_n` has fallen, then rewrites frame length, phase and polarity. It then counts `sclk` transitions and checks the looped-back word against the original eight-bit setting. A bench-side serial slave sets `miso` on the opposite edge from the capture edge in every phase mode. This way a wrong capture edge shows up as a corrupted word, not as a timing artefact.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam int FM_DATA_W = 16;
  localparam int FM_DIV_W  = 8;

  typedef enum logic [1:0] {
    FM_IDLE = 2'd0,
    FM_RUN  = 2'd1,
    FM_GAP  = 2'd2
  } fm_state_e;
endpackage

// File: rtl/spi_fm_divider.sv
module spi_fm_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] pre_q,
  input  logic [DIV_W-1:0] rate_q,
  output logic             tick
);
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] half_eff;
  logic [DIV_W-1:0] pc_last;
  logic [DIV_W-1:0] pc_q;
  logic [DIV_W-1:0] rc_q;
  logic             pre_pulse;

  assign half      = pre_q >> 1;
  assign half_eff  = (half == '0) ? DIV_W'(1) : half;
  assign pc_last   = half_eff - DIV_W'(1);
  assign pre_pulse = run && (pc_q == pc_last);
  assign tick      = pre_pulse && (rc_q == rate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      rc_q <= '0;
    end else if (!run) begin
      pc_q <= '0;
      rc_q <= '0;
    end else if (pre_pulse) begin
      pc_q <= '0;
      rc_q <= (rc_q == rate_q) ? '0 : rc_q + DIV_W'(1);
    end else begin
      pc_q <= pc_q + DIV_W'(1);
    end
  end

  // cycle counter kept only to check the half-bit spacing
  logic [31:0] gap_cyc;
  logic [31:0] gap_exp;
  assign gap_exp = 32'(half_eff) * (32'(rate_q) + 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_cyc <= 32'd1;
    else if (!run || tick) gap_cyc <= 32'd1;
    else                 gap_cyc <= gap_cyc + 32'd1;
  end

  AST_HALF_BIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_cyc == gap_exp)); // R2
endmodule

// File: rtl/spi_fm_sequencer.sv
module spi_fm_sequencer import spi_fm_pkg::*; #(
  parameter int DIV_W  = 8,
  parameter int SIZE_W = 4,
  parameter int KW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [SIZE_W-1:0] size_m1,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              loop_en,
  input  logic [DIV_W-1:0]  presc,
  input  logic [DIV_W-1:0]  rate,
  input  logic              tick,
  output logic              run,
  output logic [DIV_W-1:0]  pre_q,
  output logic [DIV_W-1:0]  rate_q,
  output logic              load,
  output logic              samp,
  output logic              shift,
  output logic              finish,
  output logic              active,
  output logic              loop_q,
  output logic              sclk,
  output logic              cs_n,
  output logic              busy
);
  fm_state_e         state_q;
  logic [KW-1:0]     k_q;
  logic [KW-1:0]     last_edge;
  logic [SIZE_W-1:0] size_q;
  logic              cpha_q;
  logic              cpol_q;
  logic              sclk_q;
  logic              cs_n_q;
  logic              frame_tick;
  logic              edge_ev;

  assign tx_ready   = (state_q == FM_IDLE) && en;
  assign load       = tx_ready && tx_valid;
  assign run        = (state_q != FM_IDLE);
  assign last_edge  = (KW'(size_q) + KW'(1)) << 1;
  assign frame_tick = (state_q == FM_RUN) && tick;
  assign edge_ev    = frame_tick && (k_q != last_edge);
  assign finish     = frame_tick && (k_q == last_edge);
  assign samp       = edge_ev && (k_q[0] == cpha_q);
  assign shift      = edge_ev && (k_q[0] != cpha_q) && (k_q != '0);
  assign active     = !cs_n_q;
  assign sclk       = sclk_q;
  assign cs_n       = cs_n_q;
  assign busy       = run || tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FM_IDLE;
      k_q     <= '0;
      size_q  <= '0;
      cpha_q  <= 1'b0;
      cpol_q  <= 1'b0;
      loop_q  <= 1'b0;
      pre_q   <= '0;
      rate_q  <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        FM_IDLE: begin
          sclk_q <= cpol;
          if (load) begin
            state_q <= FM_RUN;
            k_q     <= '0;
            cs_n_q  <= 1'b0;
            size_q  <= size_m1;
            cpha_q  <= cpha;
            cpol_q  <= cpol;
            loop_q  <= loop_en;
            pre_q   <= presc & ~DIV_W'(1);
            rate_q  <= rate;
          end
        end
        FM_RUN: begin
          if (tick) k_q <= k_q + KW'(1);
          if (edge_ev) sclk_q <= ~sclk_q;
          if (finish) begin
            cs_n_q  <= 1'b1;
            state_q <= FM_GAP;
          end
        end
        FM_GAP: begin
          if (tick) state_q <= FM_IDLE;
        end
        default: state_q <= FM_IDLE;
      endcase
    end
  end

  AST_READY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (en && cs_n_q)); // R9
  AST_GAP_CLOCK_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FM_GAP) |-> (sclk_q == cpol_q)); // R3
  AST_GAP_CLOCK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FM_GAP) |-> $stable(sclk_q)); // R3
  AST_SELECT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> busy); // R8
endmodule

// File: rtl/spi_fm_datapath.sv
module spi_fm_datapath #(
  parameter int DATA_W = 16,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              samp,
  input  logic              finish,
  input  logic              active,
  input  logic              loop_q,
  input  logic [SIZE_W-1:0] size_m1,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              mosi,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] rx_q;
  logic              rx_valid_q;
  logic [SIZE_W-1:0] nb_q;
  logic [SIZE_W-1:0] lsh;
  logic              din;

  assign lsh      = SIZE_W'(MSB) - size_m1;
  assign mosi     = active && tx_sh[MSB];
  assign din      = loop_q ? tx_sh[MSB] : miso;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_q       <= '0;
      rx_valid_q <= 1'b0;
      nb_q       <= '0;
    end else begin
      rx_valid_q <= finish;
      if (load) begin
        tx_sh <= tx_data << lsh;
        rx_sh <= '0;
        nb_q  <= size_m1;
      end else begin
        if (shift) tx_sh <= tx_sh << 1;
        if (samp)  rx_sh <= {rx_sh[MSB-1:0], din};
      end
      if (finish) rx_q <= rx_sh;
    end
  end

  AST_RX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |=> !rx_valid_q); // R11
  AST_RX_ZERO_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> ((rx_q >> ({1'b0, nb_q} + (SIZE_W+1)'(1))) == '0)); // R5
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master import spi_fm_pkg::*; #(
  parameter int DATA_W = FM_DATA_W,
  parameter int DIV_W  = FM_DIV_W,
  localparam int SIZE_W = $clog2(DATA_W),
  localparam int KW     = $clog2(2 * DATA_W + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SIZE_W-1:0] size_m1,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              loop_en,
  input  logic [DIV_W-1:0]  presc,
  input  logic [DIV_W-1:0]  rate,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);
  logic             run;
  logic             tick;
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] rate_q;
  logic             load;
  logic             samp;
  logic             shift;
  logic             finish;
  logic             active;
  logic             loop_q;

  spi_fm_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .pre_q  (pre_q),
    .rate_q (rate_q),
    .tick   (tick)
  );

  spi_fm_sequencer #(.DIV_W(DIV_W), .SIZE_W(SIZE_W), .KW(KW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .size_m1  (size_m1),
    .cpol     (cpol),
    .cpha     (cpha),
    .loop_en  (loop_en),
    .presc    (presc),
    .rate     (rate),
    .tick     (tick),
    .run      (run),
    .pre_q    (pre_q),
    .rate_q   (rate_q),
    .load     (load),
    .samp     (samp),
    .shift    (shift),
    .finish   (finish),
    .active   (active),
    .loop_q   (loop_q),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .busy     (busy)
  );

  spi_fm_datapath #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shift    (shift),
    .samp     (samp),
    .finish   (finish),
    .active   (active),
    .loop_q   (loop_q),
    .size_m1  (size_m1),
    .tx_data  (tx_data),
    .miso     (miso),
    .mosi     (mosi),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

  AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && cs_n) |=> cs_n); // R9
endmodule

// File: tb/tb_spi_frame_master.sv
module tb_spi_frame_master;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  size_m1 = 4'd7;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic        loop_en = 1'b0;
  logic [7:0]  presc = 8'd2;
  logic [7:0]  rate = 8'd0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic        rx_valid;
  logic [15:0] rx_data;
  logic        busy;
  logic        sclk;
  logic        mosi;
  logic        cs_n;
  logic        miso;

  int errors = 0;
  int checks = 0;

  spi_frame_master dut (
    .clk(clk), .rst_n(rst_n), .en(en), .size_m1(size_m1), .cpol(cpol),
    .cpha(cpha), .loop_en(loop_en), .presc(presc), .rate(rate),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench-side serial slave and timing monitor
  int          tb_n = 8;
  logic        tb_cpol = 1'b0;
  logic        tb_cpha = 1'b0;
  logic [15:0] slv_out = '0;
  logic [15:0] slv_in = '0;
  int          out_idx = 0;
  int          edge_cnt = 0;
  int          fall_cnt = 0;
  time         t_fall = 0, t_rise = 0, t_first = 0, t_second = 0, t_last = 0;
  int          rx_cnt = 0;
  logic [15:0] rx_last = '0;

  initial miso = 1'b0;

  always @(negedge cs_n) begin
    t_fall = $time;
    fall_cnt++;
    edge_cnt = 0;
    slv_in = '0;
    out_idx = 0;
    if (!tb_cpha) begin
      miso = slv_out[tb_n-1];
      out_idx = 1;
    end
  end

  always @(posedge cs_n) t_rise = $time;

  always @(sclk) begin
    if (rst_n && cs_n === 1'b0) begin
      edge_cnt++;
      if (edge_cnt == 1) t_first = $time;
      if (edge_cnt == 2) t_second = $time;
      t_last = $time;
      if ((sclk != tb_cpol) == !tb_cpha) begin
        slv_in = {slv_in[14:0], mosi};
      end else begin
        if (out_idx < tb_n) miso = slv_out[tb_n-1-out_idx];
        out_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_last = rx_data;
      rx_cnt++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  function automatic longint half_cycles(input int pr, input int rt);
    int p2;
    p2 = (pr & 8'hFE) >> 1;
    if (p2 == 0) p2 = 1;
    return longint'(p2) * longint'(rt + 1);
  endfunction

  function automatic logic [15:0] low_mask(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic set_cfg(input int n, input logic cp, input logic ph, input logic lb,
                         input int pr, input int rt, input logic [15:0] sld);
    size_m1 = 4'(n - 1);
    cpol    = cp;
    cpha    = ph;
    loop_en = lb;
    presc   = 8'(pr);
    rate    = 8'(rt);
    tb_n    = n;
    tb_cpol = cp;
    tb_cpha = ph;
    slv_out = sld;
    en      = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // offer a word and return at the negedge after it was taken
  task automatic push_word(input logic [15:0] d, input bit drop);
    int guard;
    tx_data  = d;
    tx_valid = 1'b1;
    guard = 0;
    while (!tx_ready && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    if (drop) tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int target, input string what);
    int guard;
    guard = 0;
    while (rx_cnt < target && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    if (rx_cnt < target) chk(1'b0, what, rx_cnt, target);
  endtask

  task automatic settle(input longint h);
    repeat (int'(h) * 2 + 4) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input logic cp, input logic ph, input logic lb,
                           input int pr, input int rt, input logic [15:0] txd,
                           input logic [15:0] sld);
    longint h;
    logic [15:0] exp_rx;
    int base;
    h = half_cycles(pr, rt);
    set_cfg(n, cp, ph, lb, pr, rt, sld);
    base = rx_cnt;
    push_word(txd, 1'b1);
    wait_rx(base + 1, "R11 no rx_valid after frame");
    exp_rx = lb ? (txd & low_mask(n)) : (sld & low_mask(n));
    chk(rx_last == exp_rx, lb ? "R6 loopback word" : "R4 received word", rx_last, exp_rx);
    chk(slv_in[15:0] == (txd & low_mask(n)), "R5 bits seen on mosi", slv_in, txd & low_mask(n));
    chk(edge_cnt == 2 * n, "R1 sclk transitions per frame", edge_cnt, 2 * n);
    chk((t_first - t_fall) == h * CLK_PERIOD, "R7 select lead time", t_first - t_fall, h * CLK_PERIOD);
    chk((t_rise - t_last) == h * CLK_PERIOD, "R7 select trail time", t_rise - t_last, h * CLK_PERIOD);
    chk((t_second - t_first) == h * CLK_PERIOD, "R2 half bit length", t_second - t_first, h * CLK_PERIOD);
    chk(rx_valid == 1'b0, "R11 rx_valid single cycle", rx_valid, 0);
    chk(sclk == cp, "R3 sclk rest level", sclk, cp);
    settle(h);
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1, "R7 cs_n high after reset", cs_n, 1);
    chk(sclk == 1'b0, "R3 sclk low after reset", sclk, 0);
    chk(busy == 1'b0, "R8 busy low after reset", busy, 0);
    chk(rx_valid == 1'b0, "R11 rx_valid low after reset", rx_valid, 0);
    chk(tx_ready == 1'b0, "R9 tx_ready low while disabled", tx_ready, 0);
  endtask

  task automatic t_modes();
    run_frame(8, 1'b0, 1'b0, 1'b0, 2, 0, 16'h00A5, 16'h003C); // R4 mode 0
    run_frame(8, 1'b0, 1'b1, 1'b0, 2, 1, 16'h0096, 16'h00E1); // R4 mode 1
    run_frame(8, 1'b1, 1'b0, 1'b0, 4, 0, 16'h005A, 16'h0081); // R4 mode 2
    run_frame(8, 1'b1, 1'b1, 1'b0, 2, 2, 16'h00C3, 16'h0017); // R4 mode 3
  endtask

  task automatic t_lengths();
    run_frame(4, 1'b0, 1'b0, 1'b1, 2, 0, 16'hFFFF, 16'h0000);  // R5 zero fill
    chk(rx_last == 16'h000F, "R5 upper bits zero", rx_last, 16'h000F);
    run_frame(16, 1'b0, 1'b1, 1'b1, 2, 0, 16'hB00D, 16'h0000); // R1 longest
    run_frame(11, 1'b1, 1'b0, 1'b0, 2, 0, 16'h0555, 16'h02AB); // R1 odd length
  endtask

  task automatic t_loop();
    run_frame(8, 1'b0, 1'b0, 1'b1, 2, 0, 16'h0069, 16'h00FF); // R6 miso ignored
    run_frame(8, 1'b1, 1'b1, 1'b1, 2, 0, 16'h0012, 16'h00FF); // R6 other phase
  endtask

  task automatic t_rates();
    run_frame(6, 1'b0, 1'b0, 1'b0, 5, 2, 16'h002D, 16'h0013); // R2 odd prescale -> 4
    run_frame(6, 1'b0, 1'b0, 1'b0, 1, 0, 16'h0011, 16'h0022); // R2 prescale 0 acts as 2
    run_frame(6, 1'b0, 1'b0, 1'b0, 8, 0, 16'h003F, 16'h0001); // R2 prescale 8
  endtask

  task automatic t_enable();
    int falls;
    int guard;
    set_cfg(8, 1'b0, 1'b0, 1'b1, 2, 0, 16'h0000);
    en = 1'b0;
    falls = fall_cnt;
    tx_data = 16'h0033;
    tx_valid = 1'b1;
    repeat (40) @(negedge clk);
    chk(fall_cnt == falls, "R9 no frame while disabled", fall_cnt, falls);
    chk(tx_ready == 1'b0, "R9 tx_ready low while disabled", tx_ready, 0);
    chk(busy == 1'b1, "R8 busy with waiting word", busy, 1);
    en = 1'b1;
    guard = 0;
    while (!tx_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    tx_valid = 1'b0;
    wait_rx(rx_cnt + 1, "R9 frame after enable");
    chk(rx_last == 16'h0033, "R9 word sent after enable", rx_last, 16'h0033);
    settle(1);
    chk(busy == 1'b0, "R8 busy low when idle", busy, 0);
  endtask

  task automatic t_back_to_back();
    time rise1;
    longint h;
    int base;
    h = half_cycles(6, 0);
    set_cfg(5, 1'b0, 1'b0, 1'b1, 6, 0, 16'h0000);
    base = rx_cnt;
    push_word(16'h0015, 1'b0);
    tx_data = 16'h000A;
    wait_rx(base + 1, "R11 first of pair");
    rise1 = t_rise;
    chk(rx_last == 16'h0015, "R6 first word of pair", rx_last, 16'h0015);
    chk(busy == 1'b1, "R8 busy with next word waiting", busy, 1);
    push_word(16'h000A, 1'b1);
    wait_rx(base + 2, "R11 second of pair");
    chk(rx_last == 16'h000A, "R6 second word of pair", rx_last, 16'h000A);
    chk(t_fall > rise1, "R7 select rose between frames", t_fall, rise1);
    chk((t_fall - rise1) >= h * CLK_PERIOD, "R7 select high gap", t_fall - rise1, h * CLK_PERIOD);
    settle(h);
  endtask

  task automatic t_cfg_hold();
    int base;
    int guard;
    set_cfg(8, 1'b0, 1'b0, 1'b1, 4, 0, 16'h0000);
    base = rx_cnt;
    push_word(16'h00B7, 1'b1);
    guard = 0;
    while (cs_n && guard < 100) begin @(negedge clk); guard++; end
    size_m1 = 4'd15;
    cpha    = 1'b1;
    cpol    = 1'b1;
    presc   = 8'd20;
    wait_rx(base + 1, "R10 frame after change");
    chk(edge_cnt == 16, "R10 frame length kept", edge_cnt, 16);
    chk(rx_last == 16'h00B7, "R10 word intact", rx_last, 16'h00B7);
    chk((t_second - t_first) == 2 * CLK_PERIOD, "R10 rate kept", t_second - t_first, 2 * CLK_PERIOD);
    settle(2);
    chk(sclk == 1'b1, "R3 rest level follows new cpol", sclk, 1);
    cpol = 1'b0;
    cpha = 1'b0;
    settle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_lengths();
    t_loop();
    t_rates();
    t_enable();
    t_back_to_back();
    t_cfg_hold();
    summary();
    $finish;
  end
endmodule